// File: doc/BRIEF.md
# DMA Event Status and Interrupt Register Block

This block sits beside the transmit and receive DMA engines of an Ethernet MAC and turns their per-cycle event pulses into software-visible status. The transmit side reports "frame sent" and "ran out of descriptors". The receive side reports "frame stored" and "no free descriptor". Each side keeps an 8-bit count of completed frames, a completion flag and a sticky error flag.

Software reads and acknowledges this state through a word-wide register port. It chooses the events that may raise the single interrupt line through a mask register. A completion acknowledge takes back one frame at a time. The completion flag stays up until every counted frame has been acknowledged, so a driver can acknowledge in a loop without losing frames that arrive while it runs.

The register port decodes the low address bits as a word index:
- index 0 is transmit status;
- index 1 is receive status;
- index 2 is the interrupt mask;
- index 3 is the masked interrupt status.

Reads are combinational from the current register state. Writes take effect at the clock edge.

Top module: `dma_stat_irq`

## Requirements
- R1: While `rstN` is low, and in the cycles after it is released with no other activity, every register (status, mask, interrupt status) reads zero and `irqOut` is low.
- R2: A cycle with `evTxSent` (or `evRxRecv`) high adds one to the transmit (or receive) frame count and sets its completion flag. The count is read in bits 23:16 and the flag in bit 0 of status index 0 (or 1).
- R3: Writing a word with bit 0 set to a status index subtracts one from that count. The completion flag is cleared only when the new count is zero; otherwise it stays set.
- R4: When a frame event and a completion acknowledge hit the same channel in the same cycle, the count does not change and the completion flag is set afterwards.
- R5: Counts wrap modulo 256 in both directions. An event at 255 gives 0 with the flag set. An acknowledge at 0 gives 255 and leaves the flag as it was.
- R6: `evTxUnder` sets transmit status bit 1 and `evRxOver` sets receive status bit 2. Each is sticky and is cleared only by writing one to that same bit. Writing zero has no effect. A set and a clear in the same cycle leave the flag set.
- R7: Reading index 3 returns the mask ANDed with a raw word. That raw word holds receive status bits 3:0 in bits 7:4 and transmit status bits 3:0 in bits 3:0, with zeros above. Writes to index 3 change nothing.
- R8: `irqOut` is high exactly when the index-3 value is nonzero.
- R9: Index 2 stores and reads back all 32 written bits. Only bits 7:0 take part in the interrupt, and no other stimulus changes the mask.
- R10: A cycle with `swReset` high leaves every count, flag and the mask at zero afterwards, even if events or writes arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swReset | input | 1 | Synchronous clear of all counts, flags and mask |
| evTxSent | input | 1 | Transmit frame completed pulse |
| evTxUnder | input | 1 | Transmit ran out of descriptors pulse |
| evRxRecv | input | 1 | Receive frame stored pulse |
| evRxOver | input | 1 | Receive found no free descriptor pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| irqOut | output | 1 | Interrupt request, high while masked status is nonzero |

## Verification
The bench feeds the block three kinds of pattern:
- Isolated single events, whose read-back separates count placement from flag placement.
- Acknowledge runs that walk a count down to zero, which tell "flag follows count" apart from "write clears flag".
- Deliberate collisions on one channel (event with acknowledge, error set with error clear, software clear with events), which expose any priority or net-change mistake.

Long runs of events and acknowledges push both counts across their wrap points. A random mix of events and writes to all four indices is then checked against a behavioural model on every cycle. Because the masked value is compared while the mask hides one side, a swapped or misplaced nibble in the interrupt word is caught.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

  localparam int STAT_CHANS = 2;   // index 0 transmit, index 1 receive
  localparam int NIB_W      = 4;   // status bits per channel fed to the interrupt word

  typedef enum logic [1:0] {
    ADDR_TX   = 2'd0,
    ADDR_RX   = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_ISR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [STAT_CHANS-1:0] pktInc;
    logic [STAT_CHANS-1:0] pktAck;
    logic [STAT_CHANS-1:0] errSet;
    logic [STAT_CHANS-1:0] errClr;
    logic                  maskWr;
    logic                  clrAll;
  } statStrb_t;

endpackage

// File: rtl/dma_stat_ctrl.sv
module dma_stat_ctrl
  import dma_stat_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int TX_ERR_BIT = 1,
  parameter int RX_ERR_BIT = 2,
  parameter int FLAG_W     = 3
) (
  input  logic              swReset,
  input  logic              evTxSent,
  input  logic              evTxUnder,
  input  logic              evRxRecv,
  input  logic              evRxOver,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [FLAG_W-1:0] regWrBits,
  output statStrb_t         strb
);

  logic wrTx, wrRx;

  assign wrTx = regWrEn && (regAddr == ADDR_W'(ADDR_TX));
  assign wrRx = regWrEn && (regAddr == ADDR_W'(ADDR_RX));

  always_comb begin
    strb           = '0;
    strb.pktInc[0] = evTxSent;
    strb.errSet[0] = evTxUnder;
    strb.pktAck[0] = wrTx && regWrBits[0];
    strb.errClr[0] = wrTx && regWrBits[TX_ERR_BIT];
    strb.pktInc[1] = evRxRecv;
    strb.errSet[1] = evRxOver;
    strb.pktAck[1] = wrRx && regWrBits[0];
    strb.errClr[1] = wrRx && regWrBits[RX_ERR_BIT];
    strb.maskWr    = regWrEn && (regAddr == ADDR_W'(ADDR_MASK));
    strb.clrAll    = swReset;
  end

endmodule

// File: rtl/dma_stat_chan.sv
module dma_stat_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrAll,
  input  logic             pktInc,
  input  logic             pktAck,
  input  logic             errSet,
  input  logic             errClr,
  output logic [CNT_W-1:0] cntQ,
  output logic             doneQ,
  output logic             errQ
);

  logic [CNT_W-1:0] cntNext;

  always_comb begin
    cntNext = cntQ;
    if (pktInc && !pktAck)      cntNext = cntQ + 1'b1;
    else if (pktAck && !pktInc) cntNext = cntQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else if (clrAll) begin
      cntQ  <= '0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      cntQ <= cntNext;
      if (pktInc)                         doneQ <= 1'b1;
      else if (pktAck && cntNext == '0)   doneQ <= 1'b0;
      if (errSet)                         errQ  <= 1'b1;
      else if (errClr)                    errQ  <= 1'b0;
    end
  end

  // R2
  pkt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktInc && !clrAll) |=> doneQ);

  // R3
  ack_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktAck && !pktInc && !clrAll && cntQ == CNT_W'(1)) |=> (!doneQ && cntQ == '0));

  // R4
  net_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktInc && pktAck && !clrAll) |=> $stable(cntQ));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !errClr && !clrAll) |=> errQ);

  // R10
  clr_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> (cntQ == '0 && !doneQ && !errQ));

endmodule

// File: rtl/dma_stat_dp.sv
module dma_stat_dp
  import dma_stat_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 8,
  parameter int CNT_LSB    = 16,
  parameter int ADDR_W     = 2,
  parameter int TX_ERR_BIT = 1,
  parameter int RX_ERR_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrb_t         strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);

  localparam int ISR_W = STAT_CHANS * NIB_W;

  logic [STAT_CHANS-1:0][CNT_W-1:0]  cntArr;
  logic [STAT_CHANS-1:0]             doneArr;
  logic [STAT_CHANS-1:0]             errArr;
  logic [STAT_CHANS-1:0][DATA_W-1:0] chanWord;
  logic [ISR_W-1:0]                  rawIsr;
  logic [DATA_W-1:0]                 isrVal;
  logic [DATA_W-1:0]                 maskQ;

  for (genvar i = 0; i < STAT_CHANS; i++) begin : g_chan
    localparam int ERR_POS = (i == 0) ? TX_ERR_BIT : RX_ERR_BIT;

    dma_stat_chan #(.CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .clrAll (strb.clrAll),
      .pktInc (strb.pktInc[i]),
      .pktAck (strb.pktAck[i]),
      .errSet (strb.errSet[i]),
      .errClr (strb.errClr[i]),
      .cntQ   (cntArr[i]),
      .doneQ  (doneArr[i]),
      .errQ   (errArr[i])
    );

    assign chanWord[i] = (DATA_W'(cntArr[i]) << CNT_LSB)
                       | (DATA_W'(errArr[i]) << ERR_POS)
                       | DATA_W'(doneArr[i]);
    assign rawIsr[i*NIB_W +: NIB_W] = chanWord[i][NIB_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.clrAll) maskQ <= '0;
    else if (strb.maskWr) maskQ <= regWrData;
  end

  assign isrVal = maskQ & DATA_W'(rawIsr);
  assign irqOut = |isrVal;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_TX))        regRdData = chanWord[0];
    else if (regAddr == ADDR_W'(ADDR_RX))   regRdData = chanWord[1];
    else if (regAddr == ADDR_W'(ADDR_MASK)) regRdData = maskQ;
    else if (regAddr == ADDR_W'(ADDR_ISR))  regRdData = isrVal;
  end

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ[ISR_W-1:0] != '0));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.maskWr && !strb.clrAll) |=> $stable(maskQ));

endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq #(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 8,
  parameter int CNT_LSB    = 16,
  parameter int ADDR_W     = 2,
  parameter int TX_ERR_BIT = 1,
  parameter int RX_ERR_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              evTxSent,
  input  logic              evTxUnder,
  input  logic              evRxRecv,
  input  logic              evRxOver,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);

  localparam int FLAG_W = ((TX_ERR_BIT > RX_ERR_BIT) ? TX_ERR_BIT : RX_ERR_BIT) + 1;

  dma_stat_pkg::statStrb_t strb;

  dma_stat_ctrl #(
    .ADDR_W(ADDR_W), .TX_ERR_BIT(TX_ERR_BIT), .RX_ERR_BIT(RX_ERR_BIT), .FLAG_W(FLAG_W)
  ) u_ctrl (
    .swReset   (swReset),
    .evTxSent  (evTxSent),
    .evTxUnder (evTxUnder),
    .evRxRecv  (evRxRecv),
    .evRxOver  (evRxOver),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrBits (regWrData[FLAG_W-1:0]),
    .strb      (strb)
  );

  dma_stat_dp #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB), .ADDR_W(ADDR_W),
    .TX_ERR_BIT(TX_ERR_BIT), .RX_ERR_BIT(RX_ERR_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/dma_stat_irq_test.sv
module dma_stat_irq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReset = 1'b0;
  logic        evTxSent = 1'b0, evTxUnder = 1'b0, evRxRecv = 1'b0, evRxOver = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int  mTxCnt, mRxCnt;
  bit  mTxDone, mTxUnd, mRxDone, mRxOvf;
  logic [31:0] mMask;

  dma_stat_irq uut (
    .clk(clk), .rstN(rstN), .swReset(swReset),
    .evTxSent(evTxSent), .evTxUnder(evTxUnder), .evRxRecv(evRxRecv), .evRxOver(evRxOver),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] txWord();
    return (32'(mTxCnt) << 16) | (32'(mTxUnd) << 1) | 32'(mTxDone);
  endfunction

  function automatic logic [31:0] rxWord();
    return (32'(mRxCnt) << 16) | (32'(mRxOvf) << 2) | 32'(mRxDone);
  endfunction

  function automatic logic [31:0] isrWord();
    logic [31:0] raw;
    raw = {24'd0, rxWord() & 32'hF, 4'd0} | (txWord() & 32'hF);
    raw = {24'd0, rxWord() [3:0], txWord() [3:0]};
    return raw & mMask;
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return txWord();
      2'd1: return rxWord();
      2'd2: return mMask;
      default: return isrWord();
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN || swReset) begin
      mTxCnt = 0; mRxCnt = 0; mTxDone = 0; mTxUnd = 0; mRxDone = 0; mRxOvf = 0; mMask = 0;
    end else begin
      bit txAck, rxAck, txClr, rxClr;
      txAck = regWrEn && regAddr == 2'd0 && regWrData[0];
      txClr = regWrEn && regAddr == 2'd0 && regWrData[1];
      rxAck = regWrEn && regAddr == 2'd1 && regWrData[0];
      rxClr = regWrEn && regAddr == 2'd1 && regWrData[2];
      mTxCnt = (mTxCnt + int'(evTxSent) - int'(txAck) + 256) % 256;
      mRxCnt = (mRxCnt + int'(evRxRecv) - int'(rxAck) + 256) % 256;
      if (evTxSent) mTxDone = 1; else if (txAck && mTxCnt == 0) mTxDone = 0;
      if (evRxRecv) mRxDone = 1; else if (rxAck && mRxCnt == 0) mRxDone = 0;
      if (evTxUnder) mTxUnd = 1; else if (txClr) mTxUnd = 0;
      if (evRxOver) mRxOvf = 1; else if (rxClr) mRxOvf = 0;
      if (regWrEn && regAddr == 2'd2) mMask = regWrData;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus, then compare readback and interrupt with the model
  task automatic step(input string tag, input logic tS, input logic tU, input logic rR,
                      input logic rO, input logic we, input logic [1:0] a,
                      input logic [31:0] d, input logic sr);
    evTxSent = tS; evTxUnder = tU; evRxRecv = rR; evRxOver = rO;
    regWrEn = we; regAddr = a; regWrData = d; swReset = sr;
    @(posedge clk);
    @(negedge clk);
    evTxSent = 0; evTxUnder = 0; evRxRecv = 0; evRxOver = 0; regWrEn = 0; swReset = 0;
    #1;
    check(tag, regRdData, expRead(a));
    check({tag, " irq R8"}, 32'(irqOut), 32'(isrWord() != 0));
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 2'd0, 32'd0, 0);
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d);
    step(tag, 0, 0, 0, 0, 1, a, d, 0);
  endtask

  // combinational read with a literal expectation, also compared to the model
  task automatic peek(input string tag, input logic [1:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
    check({tag, " model"}, regRdData, expRead(a));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    peek("R1", 2'd0, 32'h0); peek("R1", 2'd1, 32'h0);
    peek("R1", 2'd2, 32'h0); peek("R1", 2'd3, 32'h0);
    check("R1 irq", 32'(irqOut), 32'h0);
    @(negedge clk);
    rstN = 1;
    idle("R1"); idle("R1");
    peek("R1", 2'd3, 32'h0);

    // R2: three transmit completions
    repeat (3) step("R2", 1, 0, 0, 0, 0, 2'd0, 32'd0, 0);
    peek("R2", 2'd0, 32'h0003_0001);

    // R9: mask keeps every written bit
    wr("R9", 2'd2, 32'hFFFF_FF0F);
    peek("R9", 2'd2, 32'hFFFF_FF0F);

    // R7: masked status, writes to it ignored
    peek("R7", 2'd3, 32'h0000_0001);
    check("R8 irq high", 32'(irqOut), 32'h1);
    wr("R7", 2'd3, 32'hFFFF_FFFF);
    peek("R7", 2'd3, 32'h0000_0001);
    peek("R7", 2'd0, 32'h0003_0001);
    peek("R9", 2'd2, 32'hFFFF_FF0F);

    // R3: acknowledge walks count down, flag drops only at zero
    wr("R3", 2'd0, 32'h1); peek("R3", 2'd0, 32'h0002_0001);
    wr("R3", 2'd0, 32'h1); peek("R3", 2'd0, 32'h0001_0001);
    wr("R3", 2'd0, 32'h1); peek("R3", 2'd0, 32'h0000_0000);
    check("R8 irq low", 32'(irqOut), 32'h0);

    // R4: event with acknowledge in the same cycle
    step("R4", 1, 0, 0, 0, 1, 2'd0, 32'h1, 0);
    peek("R4", 2'd0, 32'h0000_0001);
    step("R4", 1, 0, 0, 0, 0, 2'd0, 32'h0, 0);
    step("R4", 1, 0, 0, 0, 1, 2'd0, 32'h1, 0);
    peek("R4", 2'd0, 32'h0001_0001);

    // R6: sticky error flags
    step("R6", 0, 1, 0, 0, 0, 2'd0, 32'h0, 0);
    peek("R6", 2'd0, 32'h0001_0003);
    wr("R6", 2'd0, 32'h0);
    peek("R6", 2'd0, 32'h0001_0003);
    wr("R6", 2'd0, 32'h2);
    peek("R6", 2'd0, 32'h0001_0001);
    step("R6", 0, 1, 0, 0, 1, 2'd0, 32'h2, 0);
    peek("R6", 2'd0, 32'h0001_0003);
    wr("R6", 2'd0, 32'h2);
    step("R6", 0, 0, 0, 1, 0, 2'd1, 32'h0, 0);
    peek("R6", 2'd1, 32'h0000_0004);
    peek("R7", 2'd3, 32'h0000_0001);
    wr("R7", 2'd2, 32'h0000_00FF);
    peek("R7", 2'd3, 32'h0000_0041);
    wr("R6", 2'd1, 32'h4);
    peek("R6", 2'd1, 32'h0);

    // R5: wrap in both directions
    repeat (256) step("R5", 0, 0, 1, 0, 0, 2'd1, 32'h0, 0);
    peek("R5", 2'd1, 32'h0000_0001);
    wr("R5", 2'd1, 32'h1);
    peek("R5", 2'd1, 32'h00FF_0001);
    wr("R5", 2'd0, 32'h1);
    peek("R5", 2'd0, 32'h0000_0000);
    wr("R5", 2'd0, 32'h1);
    peek("R5", 2'd0, 32'h00FF_0000);

    // mixed random traffic compared with the model every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rnd;
      rnd = $urandom;
      step("R8 mix", rnd[0], rnd[1] & rnd[2] & rnd[3], rnd[4], rnd[5] & rnd[6] & rnd[7],
           rnd[8], rnd[10:9], $urandom, (rnd[20:14] == 7'd0));
    end

    // R10: clear wins over same-cycle activity
    repeat (4) step("R10", 1, 1, 1, 1, 0, 2'd0, 32'h0, 0);
    wr("R10", 2'd2, 32'h0000_00FF);
    step("R10", 1, 1, 1, 1, 1, 2'd2, 32'h0000_00FF, 1);
    peek("R10", 2'd0, 32'h0); peek("R10", 2'd1, 32'h0);
    peek("R10", 2'd2, 32'h0); peek("R10", 2'd3, 32'h0);
    check("R10 irq", 32'(irqOut), 32'h0);

    // R1: asynchronous reset with state present
    repeat (2) step("R1", 1, 1, 1, 1, 0, 2'd0, 32'h0, 0);
    wr("R1", 2'd2, 32'hFF);
    rstN = 0;
    #1;
    peek("R1", 2'd0, 32'h0); peek("R1", 2'd1, 32'h0); peek("R1", 2'd2, 32'h0);
    check("R1 irq", 32'(irqOut), 32'h0);
    @(negedge clk);
    rstN = 1;
    idle("R1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule